// File: doc/BRIEF.md
# Same-Word Collision Arbiter for a Two-Port Memory

This block sits in front of a memory array that two independent ports share. Each port presents an enable, a word address and a write strobe. Both ports run on one common clock. When both ports select the same word in the same cycle, the block decides which one may go on. In the other direction it drives an active-low busy flag, and it gates the write strobe of the losing port. The memory array uses the per-port internal write enables that the block produces.

The winner is the port whose enable and address were already held unchanged from the previous cycle. The other port arrived later, so it gets busy. If both requests appear in the same cycle, a fixed tie-break parameter picks the winner. Once a collision is resolved, a registered owner state keeps the decision for as long as the collision lasts.

A mode input selects the role of the busy pins. In master mode the block drives the busy flags itself. In slave mode the busy flags come in from outside, and each one only blocks writes from its own port.

Top module: `busy_arb`

## Requirements
- R1: In master mode a busy output (active low) goes to 0 only while both enables are 1 and the two addresses are equal. At all other times both busy outputs are 1.
- R2: The write strobes take no part in the arbitration. A collision between a read (wr=0) and a write gives the same busy outputs as a collision between two writes.
- R3: A port is "settled" when its enable was 1 in the previous cycle and in the current cycle, with the same address in both. When a collision starts, a settled port wins against a port that is not settled. The losing port sees busy=0.
- R4: The two busy outputs are never 0 together. When a collision starts and both ports are settled, or neither is, exactly one port gets busy. With TIE_LEFT=1 (the default) that port is the right one.
- R5: The internal write enable of a port is enable AND wr AND not blocked. In master mode a port with busy=0 is blocked. The external busy inputs have no effect in master mode.
- R6: In slave mode (mode_master=0) both busy outputs stay 1. A port is blocked exactly when its busy input is 0; a busy input of 1 allows normal writes.
- R7: Busy returns to 1 in the cycle in which the addresses stop matching, or in which either enable goes to 0.
- R8: While a collision lasts without a break, the winner does not change. This holds even when both addresses move together to a new common word.
- R9: While rst is 1, both busy outputs are 1 and both write enables are 0. Reset clears the settled history, so a collision that is present in the first cycle after reset is resolved by the tie-break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| mode_master | input | 1 | 1: block drives busy; 0: busy inputs gate writes |
| lf_ce | input | 1 | Left port enable, active high |
| lf_addr | input | ADDR_W | Left port word address |
| lf_wr | input | 1 | Left port write strobe (1 = write) |
| lf_busy_in_n | input | 1 | Left external busy, active low, used in slave mode |
| rt_ce | input | 1 | Right port enable, active high |
| rt_addr | input | ADDR_W | Right port word address |
| rt_wr | input | 1 | Right port write strobe (1 = write) |
| rt_busy_in_n | input | 1 | Right external busy, active low, used in slave mode |
| lf_busy_n | output | 1 | Busy flag to the left port, active low |
| rt_busy_n | output | 1 | Busy flag to the right port, active low |
| lf_wen | output | 1 | Internal write enable for the left port |
| rt_wen | output | 1 | Internal write enable for the right port |

## Verification
The stimulus steps through several kinds of arrival order:
- one port held while the other moves onto its word;
- one port re-enabling onto a word the other already holds;
- both ports arriving in the same cycle;
- both ports sliding together to a new word during a collision.

These cases tell the settled-first rule apart from the tie-break and from the held owner. Read/write collisions are compared with write/write collisions. Losing an enable is compared with an address divergence. Master mode is driven with the external busy inputs forced low, and slave mode with each busy input low in turn. These show that the external pins matter in slave mode only.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/busy_arb_track.sv
module busy_arb_track #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= ce;
      addr_q <= addr;
    end
  end

  assign settled = ce && vld_q && (addr == addr_q);

  // R3
  settled_hist_chk: assert property (@(posedge clk) disable iff (rst)
    settled |-> ($past(ce) && $past(addr) == addr && !$past(rst)));
endmodule

// File: rtl/busy_arb_core.sv
module busy_arb_core
  import busy_arb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_settled,
  input  logic              r_settled,
  output owner_e            winner,
  output logic              collide
);
  localparam owner_e TIE_OWNER = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;

  owner_e owner_q;
  owner_e fresh;

  assign collide = l_ce && r_ce && (l_addr == r_addr);

  always_comb begin
    if (l_settled && !r_settled)      fresh = OWN_LEFT;
    else if (r_settled && !l_settled) fresh = OWN_RIGHT;
    else                              fresh = TIE_OWNER;
  end

  always_comb begin
    if (!collide)                 winner = OWN_NONE;
    else if (owner_q != OWN_NONE) winner = owner_q;
    else                          winner = fresh;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= winner;
  end

  // R8
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (collide && $past(collide) && !$past(rst)) |-> (winner == $past(winner)));
endmodule

// File: rtl/busy_arb_gate.sv
module busy_arb_gate (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic ce,
  input  logic wr,
  input  logic lose,
  input  logic busy_in_n,
  output logic busy_n,
  output logic wen
);
  logic blocked;

  assign blocked = master ? lose : !busy_in_n;
  assign busy_n  = rst ? 1'b1 : !(master && lose);
  assign wen     = !rst && ce && wr && !blocked;

  // R5
  master_block_chk: assert property (@(posedge clk) disable iff (rst)
    (master && !busy_n) |-> !wen);
  // R6
  slave_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!master && !busy_in_n) |-> !wen);
  // R6
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master |-> busy_n);
endmodule

// File: rtl/busy_arb.sv
module busy_arb
  import busy_arb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_master,
  input  logic              lf_ce,
  input  logic [ADDR_W-1:0] lf_addr,
  input  logic              lf_wr,
  input  logic              lf_busy_in_n,
  input  logic              rt_ce,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_wr,
  input  logic              rt_busy_in_n,
  output logic              lf_busy_n,
  output logic              rt_busy_n,
  output logic              lf_wen,
  output logic              rt_wen
);
  logic [NUM_PORTS-1:0] ce_v, wr_v, bin_v, settled_v, lose_v, busy_v, wen_v;
  logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
  owner_e               winner;
  logic                 collide;

  assign ce_v     = {rt_ce, lf_ce};
  assign wr_v     = {rt_wr, lf_wr};
  assign bin_v    = {rt_busy_in_n, lf_busy_in_n};
  assign addr_v[0] = lf_addr;
  assign addr_v[1] = rt_addr;
  assign lose_v[0] = (winner == OWN_RIGHT);
  assign lose_v[1] = (winner == OWN_LEFT);

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
    busy_arb_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst     (rst),
      .ce      (ce_v[gi]),
      .addr    (addr_v[gi]),
      .settled (settled_v[gi])
    );

    busy_arb_gate u_gate (
      .clk       (clk),
      .rst       (rst),
      .master    (mode_master),
      .ce        (ce_v[gi]),
      .wr        (wr_v[gi]),
      .lose      (lose_v[gi]),
      .busy_in_n (bin_v[gi]),
      .busy_n    (busy_v[gi]),
      .wen       (wen_v[gi])
    );
  end

  busy_arb_core #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) u_core (
    .clk       (clk),
    .rst       (rst),
    .l_ce      (lf_ce),
    .l_addr    (lf_addr),
    .r_ce      (rt_ce),
    .r_addr    (rt_addr),
    .l_settled (settled_v[0]),
    .r_settled (settled_v[1]),
    .winner    (winner),
    .collide   (collide)
  );

  assign lf_busy_n = busy_v[0];
  assign rt_busy_n = busy_v[1];
  assign lf_wen    = wen_v[0];
  assign rt_wen    = wen_v[1];

  // R4
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!lf_busy_n && !rt_busy_n));
  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!lf_busy_n || !rt_busy_n) |->
      (mode_master && lf_ce && rt_ce && lf_addr == rt_addr));
  // R4
  one_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_master && lf_ce && rt_ce && lf_addr == rt_addr) |->
      (lf_busy_n != rt_busy_n));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !collide |-> (lf_busy_n && rt_busy_n));
endmodule

// File: tb/busy_arb_bench.sv
module busy_arb_bench;
  localparam int unsigned AW = 14;

  typedef struct packed {
    logic          m;
    logic          lce;
    logic [AW-1:0] la;
    logic          lw;
    logic          rce;
    logic [AW-1:0] ra;
    logic          rw;
    logic          lbi;
    logic          rbi;
    logic [3:0]    exp;  // {lf_busy_n, rt_busy_n, lf_wen, rt_wen}
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 14'h0000, 1'b0, 1'b0, 14'h0000, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd1}, // R1 idle
    '{1'b1, 1'b1, 14'h0100, 1'b1, 1'b0, 14'h0000, 1'b0, 1'b1, 1'b1, 4'b1110, 4'd1}, // R1 one port
    '{1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 14'h0200, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd1}, // R1 differ
    '{1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 1'b1, 4'b1010, 4'd3}, // R3 left held
    '{1'b1, 1'b1, 14'h0100, 1'b0, 1'b1, 14'h0100, 1'b1, 1'b1, 1'b1, 4'b1000, 4'd2}, // R2 read
    '{1'b1, 1'b0, 14'h0100, 1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 1'b1, 4'b1101, 4'd7}, // R7 ce drop
    '{1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 1'b1, 4'b0101, 4'd3}, // R3 right held
    '{1'b1, 1'b1, 14'h0101, 1'b1, 1'b1, 14'h0100, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd7}, // R7 diverge
    '{1'b1, 1'b0, 14'h0000, 1'b0, 1'b0, 14'h0000, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd1},
    '{1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'b1010, 4'd4}, // R4 tie
    '{1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b0, 1'b0, 4'b1010, 4'd5}, // R5 pins ignored
    '{1'b0, 1'b1, 14'h3FFF, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'b1111, 4'd6}, // R6 slave free
    '{1'b0, 1'b1, 14'h3FFF, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b0, 1'b1, 4'b1101, 4'd6}, // R6 left held off
    '{1'b0, 1'b1, 14'h3FFF, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 1'b0, 4'b1110, 4'd6}, // R6 right held off
    '{1'b1, 1'b0, 14'h0000, 1'b0, 1'b0, 14'h0000, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd7},
    '{1'b1, 1'b0, 14'h0000, 1'b0, 1'b1, 14'h0005, 1'b1, 1'b1, 1'b1, 4'b1101, 4'd1},
    '{1'b1, 1'b1, 14'h0005, 1'b1, 1'b1, 14'h0005, 1'b1, 1'b1, 1'b1, 4'b0101, 4'd3}, // R3 right held
    '{1'b1, 1'b1, 14'h0006, 1'b1, 1'b1, 14'h0006, 1'b1, 1'b1, 1'b1, 4'b0101, 4'd8}, // R8 move together
    '{1'b1, 1'b0, 14'h0000, 1'b0, 1'b0, 14'h0000, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd7}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_master = 1'b1;
  logic          lf_ce = 1'b0, rt_ce = 1'b0, lf_wr = 1'b0, rt_wr = 1'b0;
  logic          lf_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
  logic [AW-1:0] lf_addr = '0, rt_addr = '0;
  logic          lf_busy_n, rt_busy_n, lf_wen, rt_wen;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  busy_arb #(.ADDR_W(AW), .TIE_LEFT(1'b1)) u_busy_arb (
    .clk          (clk),
    .rst          (rst),
    .mode_master  (mode_master),
    .lf_ce        (lf_ce),
    .lf_addr      (lf_addr),
    .lf_wr        (lf_wr),
    .lf_busy_in_n (lf_busy_in_n),
    .rt_ce        (rt_ce),
    .rt_addr      (rt_addr),
    .rt_wr        (rt_wr),
    .rt_busy_in_n (rt_busy_in_n),
    .lf_busy_n    (lf_busy_n),
    .rt_busy_n    (rt_busy_n),
    .lf_wen       (lf_wen),
    .rt_wen       (rt_wen)
  );

  task automatic drive(input vec_t v);
    mode_master  = v.m;
    lf_ce        = v.lce;
    lf_addr      = v.la;
    lf_wr        = v.lw;
    rt_ce        = v.rce;
    rt_addr      = v.ra;
    rt_wr        = v.rw;
    lf_busy_in_n = v.lbi;
    rt_busy_in_n = v.rbi;
  endtask

  task automatic check(input logic [3:0] exp, input int req, input int idx);
    logic [3:0] got;
    got = {lf_busy_n, rt_busy_n, lf_wen, rt_wen};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", req, idx, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: outputs quiet during reset even with a collision on the inputs
    @(negedge clk);
    drive('{1'b1, 1'b1, 14'h0040, 1'b1, 1'b1, 14'h0040, 1'b1, 1'b1, 1'b1, 4'b0, 4'd9});
    #5 check(4'b1100, 9, -1);
    // R9: first cycle after reset has no history, tie goes left
    @(negedge clk);
    rst = 1'b0;
    #5 check(4'b1010, 9, -2);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #5 check(TBL[i].exp, int'(TBL[i].req), i);
    end

    // R9: reset in the middle of a collision the right port owns
    @(negedge clk);
    drive('{1'b1, 1'b0, 14'h0000, 1'b0, 1'b1, 14'h0021, 1'b1, 1'b1, 1'b1, 4'b0, 4'd9});
    @(negedge clk);
    drive('{1'b1, 1'b1, 14'h0021, 1'b1, 1'b1, 14'h0021, 1'b1, 1'b1, 1'b1, 4'b0, 4'd9});
    #5 check(4'b0101, 3, -3);
    @(negedge clk);
    rst = 1'b1;
    #5 check(4'b1100, 9, -4);
    @(negedge clk);
    rst = 1'b0;
    #5 check(4'b1010, 9, -5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule